// File: doc/BRIEF.md
# Fracturable LUT Logic Element

This block is a single configurable logic element of the kind that tiles a programmable fabric. Eight data inputs drive a 128-bit truth-table mask that is split into a lower and an upper 64-bit half. Depending on a two-bit mode, the mask acts in one of four ways. It can be two 6-input lookup tables that share four inputs. It can be a 7-input function built as a 2:1 multiplexer of two 5-input tables. It can be four 4-input tables feeding two dedicated full adders on a carry chain. Or it can be a 2-bit, three-operand carry-save adder that passes a partial carry to the next element over a separate sharing chain.

Four result bits leave the function block. Each result also feeds one of four output registers. Every register has an asynchronous clear, a synchronous clear, a synchronous load and a clock enable. Each register can take its data from a register-chain path instead of the function result, so that neighbouring elements form a shift register. Both the raw results and the register contents are brought out. A per-bit bypass selects which of the two drives the main output. The mask and the control word sit in plain registers and are written through a small word-wide write port before operation.

Top module: `frac_logic_cell`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` on the next rising edge. Address k in 0..3 writes mask bits [32k+31:32k]. Address 4 writes the control word: mode in bits [1:0] (0 normal, 1 extended, 2 arithmetic, 3 shared), register-chain selects in bits [5:2] (bit 2+k for register k) and bypass selects in bits [9:6] (bit 6+k for output k). Addresses 5..7 are ignored. Reset clears the whole configuration to zero.
- R2: In normal mode, `res[0]` = mask[{f0,e0,d,c,b,a}] and `res[1]` = mask[64 + {f1,e1,d,c,b,a}], with `res[3:2]` = 0. The data inputs are `din` bit 0 a, 1 b, 2 c, 3 d, 4 e0, 5 f0, 6 e1, 7 f1.
- R3: In extended mode, `res[0]` = e0 ? mask[64 + {f1,d,c,b,a}] : mask[{f0,d,c,b,a}], and `res[3:1]` = 0.
- R4: While the mode is extended, register 1 is cleared on every edge whatever its enable, load or chain controls say.
- R5: In arithmetic mode, four tables are used: L0 = mask[{e0,c,b,a}], L1 = mask[16 + {f0,d,b,a}], L2 = mask[64 + {e1,c,b,a}] and L3 = mask[80 + {f1,d,b,a}]. Adder 0 adds L0, L1 and `carry_in`, and adder 1 adds L2, L3 and the carry of adder 0. `res[0]` and `res[1]` are the two sums, `res[2]` is the carry of adder 0, and `res[3]` and `carry_out` are the carry of adder 1.
- R6: In shared mode, the tables are L0 = mask[{c,b,a}], L1 = mask[16 + {c,b,a}], L2 = mask[64 + {f0,e0,d}] and L3 = mask[80 + {f0,e0,d}]. Adder 0 adds L0, `share_in` and `carry_in`. Adder 1 adds L2, L1 and the carry of adder 0. `share_out` = L3, and `res[3:0]` and `carry_out` are as in R5. With XOR3 in L0/L2 and majority in L1/L3, a+b+c+2(d+e0+f0)+share_in+carry_in equals res0+2·res1+4·carry_out+4·share_out.
- R7: `carry_out` and `share_out` are 0 in normal and extended mode, and `share_out` is 0 in arithmetic mode.
- R8: `sclr` high clears every register on the next edge and overrides load and enable.
- R9: `sload` high with `sclr` low loads `ld_val[k]` into register k on the next edge, regardless of `ce`.
- R10: With `ce`, `sclr` and `sload` all low, every register holds its value.
- R11: A register whose chain select is set captures the previous register (register 0 captures `chain_in`) instead of its result when enabled. `chain_out` always shows register 3.
- R12: `dout[k]` shows `res[k]` when bypass bit k is set and `q[k]` otherwise, and `res` and `q` are always both visible.
- R13: `rst_n` low clears all registers and the configuration at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear of registers and configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| din | input | 8 | Data inputs {f1,e1,f0,e0,d,c,b,a} |
| carry_in | input | 1 | Carry from the previous element |
| share_in | input | 1 | Shared-arithmetic chain input |
| chain_in | input | 1 | Register-chain input from the previous element |
| ce | input | 1 | Register clock enable |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load |
| ld_val | input | 4 | Synchronous load values, one per register |
| res | output | 4 | Unregistered function results |
| q | output | 4 | Register outputs |
| dout | output | 4 | Bypass-selected outputs |
| carry_out | output | 1 | Carry to the next element |
| share_out | output | 1 | Shared-arithmetic chain output |
| chain_out | output | 1 | Register-chain output (register 3) |

## Verification
The assertions check on every cycle the register behaviours: configuration words landing after a write, clear priority, load, hold without enable, chain capture and the forced clear of register 1 in extended mode. They also check that the chain outputs stay quiet in the modes that do not use them. The function of each mode across masks and inputs can only be shown by the bench. It runs a behavioural model over random masks, inputs, control words and mode changes. The bench also runs directed cases: the three-bit sum against a+b+c, the full carry-save identity, the effect of a written mask word, and an asynchronous reset in mid-run.

// File: rtl/flc_pkg.sv
package flc_pkg;

    localparam int unsigned LUT_K    = 6;
    localparam int unsigned HALF_W   = 1 << LUT_K;
    localparam int unsigned MASK_W   = 2 * HALF_W;
    localparam int unsigned NUM_REGS = 4;
    localparam int unsigned DIN_W    = 8;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_EXT    = 2'd1,
        MODE_ARITH  = 2'd2,
        MODE_SHARED = 2'd3
    } flc_mode_e;

    typedef struct packed {
        flc_mode_e             mode;
        logic [NUM_REGS-1:0]   chain_sel;
        logic [NUM_REGS-1:0]   bypass;
    } flc_ctrl_t;

    // one-bit full adder: {carry, sum}
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic z);
        return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
    endfunction

endpackage

// File: rtl/flc_cfg_regs.sv
module flc_cfg_regs
    import flc_pkg::*;
#(
    parameter int unsigned CFG_W  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [MASK_W-1:0] mask,
    output flc_ctrl_t         ctrl
);

    localparam int unsigned NWORDS = MASK_W / CFG_W;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NWORDS);
    localparam int unsigned CTRL_USED = 2 + 2 * NUM_REGS;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        flc_ctrl_t         ctrl;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^cfg_wdata[CFG_W-1:CTRL_USED];

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            if (cfg_addr < CTRL_ADDR) begin
                s_d.mask[int'(cfg_addr)*CFG_W +: CFG_W] = cfg_wdata;
            end else if (cfg_addr == CTRL_ADDR) begin
                s_d.ctrl.mode      = flc_mode_e'(cfg_wdata[1:0]);
                s_d.ctrl.chain_sel = cfg_wdata[2 +: NUM_REGS];
                s_d.ctrl.bypass    = cfg_wdata[2+NUM_REGS +: NUM_REGS];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mask = s_q.mask;
    assign ctrl = s_q.ctrl;

    assert_mask_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr < CTRL_ADDR) |=>
            s_q.mask[int'($past(cfg_addr))*CFG_W +: CFG_W] == $past(cfg_wdata));

    assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CTRL_ADDR) |=>
            (s_q.ctrl.mode == $past(cfg_wdata[1:0]) &&
             s_q.ctrl.bypass == $past(cfg_wdata[2+NUM_REGS +: NUM_REGS])));

endmodule

// File: rtl/flc_lut_core.sv
module flc_lut_core
    import flc_pkg::*;
(
    input  logic [MASK_W-1:0]   mask,
    input  flc_mode_e           mode,
    input  logic [DIN_W-1:0]    din,
    input  logic                carry_in,
    input  logic                share_in,
    output logic [NUM_REGS-1:0] res,
    output logic                carry_out,
    output logic                share_out
);

    localparam int unsigned IDX_W = LUT_K;

    logic [HALF_W-1:0] lo, hi;
    logic a, b, c, d, e0, f0, e1, f1;
    logic [IDX_W-1:0] ix0, ix1, ix2, ix3;
    logic l0, l1, l2, l3;
    logic [1:0] add0, add1;
    logic leg_lo, leg_hi;

    assign lo = mask[HALF_W-1:0];
    assign hi = mask[MASK_W-1:HALF_W];
    assign {f1, e1, f0, e0, d, c, b, a} = din;

    always_comb begin
        // four small tables, wired per arithmetic flavour
        if (mode == MODE_SHARED) begin
            ix0 = {3'b000, c, b, a};
            ix1 = {3'b010, c, b, a};
            ix2 = {3'b000, f0, e0, d};
            ix3 = {3'b010, f0, e0, d};
        end else begin
            ix0 = {2'b00, e0, c, b, a};
            ix1 = {2'b01, f0, d, b, a};
            ix2 = {2'b00, e1, c, b, a};
            ix3 = {2'b01, f1, d, b, a};
        end
        l0 = lo[ix0];
        l1 = lo[ix1];
        l2 = hi[ix2];
        l3 = hi[ix3];

        if (mode == MODE_SHARED) begin
            add0 = full_add(l0, share_in, carry_in);
            add1 = full_add(l2, l1, add0[1]);
        end else begin
            add0 = full_add(l0, l1, carry_in);
            add1 = full_add(l2, l3, add0[1]);
        end

        leg_lo = lo[{1'b0, f0, d, c, b, a}];
        leg_hi = hi[{1'b0, f1, d, c, b, a}];

        res       = '0;
        carry_out = 1'b0;
        share_out = 1'b0;
        unique case (mode)
            MODE_NORMAL: begin
                res[0] = lo[{f0, e0, d, c, b, a}];
                res[1] = hi[{f1, e1, d, c, b, a}];
            end
            MODE_EXT: begin
                res[0] = e0 ? leg_hi : leg_lo;
            end
            MODE_ARITH, MODE_SHARED: begin
                res       = {add1[1], add0[1], add1[0], add0[0]};
                carry_out = add1[1];
                share_out = (mode == MODE_SHARED) ? l3 : 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flc_reg_bank.sv
module flc_reg_bank
    import flc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] res,
    input  logic                chain_in,
    input  logic                ce,
    input  logic                sclr,
    input  logic                sload,
    input  logic [NUM_REGS-1:0] ld_val,
    input  logic [NUM_REGS-1:0] chain_sel,
    input  logic                ext_mode,
    output logic [NUM_REGS-1:0] q
);

    localparam int unsigned DEAD_REG = 1;

    typedef struct packed {
        logic [NUM_REGS-1:0] q;
    } bank_state_t;

    bank_state_t s_d, s_q;
    logic [NUM_REGS-1:0] prev;
    logic [NUM_REGS-1:0] dsel;

    assign prev = {s_q.q[NUM_REGS-2:0], chain_in};

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < NUM_REGS; k++) begin
            dsel[k] = chain_sel[k] ? prev[k] : res[k];
            if (sclr)       s_d.q[k] = 1'b0;
            else if (sload) s_d.q[k] = ld_val[k];
            else if (ce)    s_d.q[k] = dsel[k];
        end
        if (ext_mode) s_d.q[DEAD_REG] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.q;

    assert_sync_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sclr |=> (q == '0));

    assert_sync_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sload && !sclr) |=> (q[0] == $past(ld_val[0]) && q[NUM_REGS-1] == $past(ld_val[NUM_REGS-1])));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !sclr && !sload) |=> $stable(q[0]));

    assert_chain_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !sclr && !sload && chain_sel[0]) |=> (q[0] == $past(chain_in)));

    assert_ext_dead_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> !q[DEAD_REG]);

endmodule

// File: rtl/frac_logic_cell.sv
module frac_logic_cell
    import flc_pkg::*;
#(
    parameter int unsigned CFG_W  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [DIN_W-1:0]    din,
    input  logic                carry_in,
    input  logic                share_in,
    input  logic                chain_in,
    input  logic                ce,
    input  logic                sclr,
    input  logic                sload,
    input  logic [NUM_REGS-1:0] ld_val,
    output logic [NUM_REGS-1:0] res,
    output logic [NUM_REGS-1:0] q,
    output logic [NUM_REGS-1:0] dout,
    output logic                carry_out,
    output logic                share_out,
    output logic                chain_out
);

    logic [MASK_W-1:0] mask;
    flc_ctrl_t         ctrl;

    flc_cfg_regs #(.CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mask      (mask),
        .ctrl      (ctrl)
    );

    flc_lut_core u_core (
        .mask      (mask),
        .mode      (ctrl.mode),
        .din       (din),
        .carry_in  (carry_in),
        .share_in  (share_in),
        .res       (res),
        .carry_out (carry_out),
        .share_out (share_out)
    );

    flc_reg_bank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .res       (res),
        .chain_in  (chain_in),
        .ce        (ce),
        .sclr      (sclr),
        .sload     (sload),
        .ld_val    (ld_val),
        .chain_sel (ctrl.chain_sel),
        .ext_mode  (ctrl.mode == MODE_EXT),
        .q         (q)
    );

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_out
        assign dout[k] = ctrl.bypass[k] ? res[k] : q[k];
    end

    assign chain_out = q[NUM_REGS-1];

    assert_quiet_chains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode inside {MODE_NORMAL, MODE_EXT}) |-> (!carry_out && !share_out));

    assert_no_share_arith_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_ARITH) |-> !share_out);

endmodule

// File: tb/frac_logic_cell_tb.sv
`timescale 1ns/1ps
module frac_logic_cell_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  din = '0;
    logic        carry_in = 1'b0, share_in = 1'b0, chain_in = 1'b0;
    logic        ce = 1'b0, sclr = 1'b0, sload = 1'b0;
    logic [3:0]  ld_val = '0;
    logic [3:0]  res, q, dout;
    logic        carry_out, share_out, chain_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frac_logic_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .din(din), .carry_in(carry_in), .share_in(share_in),
        .chain_in(chain_in), .ce(ce), .sclr(sclr), .sload(sload), .ld_val(ld_val),
        .res(res), .q(q), .dout(dout), .carry_out(carry_out),
        .share_out(share_out), .chain_out(chain_out)
    );

    // behavioural model state
    bit [127:0] m_mask;
    bit [1:0]   m_mode;
    bit [3:0]   m_chs, m_byp, m_q;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit tbl(int idx);
        return m_mask[idx];
    endfunction

    // returns {share_out, carry_out, res[3:0]}
    function automatic bit [5:0] ref_comb(bit [7:0] x, bit ci, bit si);
        int a = x[0], b = x[1], c = x[2], d = x[3];
        int e0 = x[4], f0 = x[5], e1 = x[6], f1 = x[7];
        int l0, l1, l2, l3, s0, s1;
        bit [5:0] r = '0;
        case (m_mode)
            2'd0: begin
                r[0] = tbl(a + 2*b + 4*c + 8*d + 16*e0 + 32*f0);
                r[1] = tbl(64 + a + 2*b + 4*c + 8*d + 16*e1 + 32*f1);
            end
            2'd1: begin
                if (e0 != 0) r[0] = tbl(64 + a + 2*b + 4*c + 8*d + 16*f1);
                else         r[0] = tbl(a + 2*b + 4*c + 8*d + 16*f0);
            end
            2'd2: begin
                l0 = tbl(a + 2*b + 4*c + 8*e0);
                l1 = tbl(16 + a + 2*b + 4*d + 8*f0);
                l2 = tbl(64 + a + 2*b + 4*c + 8*e1);
                l3 = tbl(80 + a + 2*b + 4*d + 8*f1);
                s0 = l0 + l1 + ci;
                s1 = l2 + l3 + s0/2;
                r[0] = s0[0]; r[1] = s1[0]; r[2] = s0[1]; r[3] = s1[1]; r[4] = s1[1];
            end
            default: begin
                l0 = tbl(a + 2*b + 4*c);
                l1 = tbl(16 + a + 2*b + 4*c);
                l2 = tbl(64 + d + 2*e0 + 4*f0);
                l3 = tbl(80 + d + 2*e0 + 4*f0);
                s0 = l0 + si + ci;
                s1 = l2 + l1 + s0/2;
                r[0] = s0[0]; r[1] = s1[0]; r[2] = s0[1]; r[3] = s1[1]; r[4] = s1[1];
                r[5] = l3[0];
            end
        endcase
        return r;
    endfunction

    function automatic string mode_tag();
        case (m_mode)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic model_reset();
        m_mask = '0; m_mode = '0; m_chs = '0; m_byp = '0; m_q = '0;
    endtask

    task automatic step(bit we, bit [2:0] ad, bit [31:0] wd, bit [7:0] x,
                        bit ci, bit si, bit chn, bit e, bit sc, bit sl, bit [3:0] ld);
        bit [5:0] r;
        bit [3:0] prev, nq;
        string rtag;
        cfg_we = we; cfg_addr = ad; cfg_wdata = wd; din = x;
        carry_in = ci; share_in = si; chain_in = chn;
        ce = e; sclr = sc; sload = sl; ld_val = ld;
        #1;
        r = ref_comb(x, ci, si);
        chk(mode_tag(), {26'd0, share_out, carry_out, res}, {26'd0, r});
        chk("R12", {28'd0, dout}, {28'd0, (m_byp & r[3:0]) | (~m_byp & m_q)});
        chk("R11", {31'd0, chain_out}, {31'd0, m_q[3]});
        @(posedge clk);
        prev = {m_q[2:0], chn};
        for (int k = 0; k < 4; k++) begin
            bit dv = m_chs[k] ? prev[k] : r[k];
            nq[k] = sc ? 1'b0 : sl ? ld[k] : e ? dv : m_q[k];
        end
        if (m_mode == 2'd1) nq[1] = 1'b0;
        m_q = nq;
        if (we) begin
            if (ad < 3'd4) m_mask[ad*32 +: 32] = wd;
            else if (ad == 3'd4) begin
                m_mode = wd[1:0]; m_chs = wd[5:2]; m_byp = wd[9:6];
            end
        end
        @(negedge clk);
        #0.1;
        rtag = sc ? "R8" : sl ? "R9" : (e && m_chs != 0) ? "R11" : (e ? "R2" : "R10");
        if (m_mode == 2'd1) rtag = "R4";
        chk(rtag, {28'd0, q}, {28'd0, m_q});
    endtask

    task automatic idle(bit [7:0] x, bit ci, bit si);
        step(1'b0, 3'd0, 32'd0, x, ci, si, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    endtask

    task automatic wcfg(bit [2:0] ad, bit [31:0] wd);
        step(1'b1, ad, wd, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13", {18'd0, q, res, dout, carry_out, share_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: a written mask word shows up in the normal-mode table
        wcfg(3'd0, 32'hAAAA_AAAA);
        din = 8'h01; #1; chk("R1", {31'd0, res[0]}, 32'd1);
        din = 8'h02; #1; chk("R1", {31'd0, res[0]}, 32'd0);
        wcfg(3'd5, 32'hFFFF_FFFF);
        din = 8'h20; #1; chk("R1", {31'd0, res[0]}, 32'd0);
        idle(8'h00, 1'b0, 1'b0);

        // R7: full mask in normal mode, chains quiet
        for (int w = 0; w < 4; w++) wcfg(3'(w), 32'hFFFF_FFFF);
        din = 8'hFF; carry_in = 1'b1; share_in = 1'b1; #1;
        chk("R7", {29'd0, res[0], carry_out, share_out}, 32'd4);
        idle(8'h00, 1'b0, 1'b0);

        // R6: carry-save adder with XOR3 / majority tables
        wcfg(3'd0, 32'h00E8_0096);
        wcfg(3'd2, 32'h00E8_0096);
        wcfg(3'd4, 32'd3);
        for (int v = 0; v < 8; v++) begin
            din = 8'(v); carry_in = 1'b0; share_in = 1'b0; #1;
            chk("R6", {29'd0, carry_out, res[1:0]}, 32'(v[0] + v[1] + v[2]));
        end
        for (int n = 0; n < 16; n++) begin
            bit [7:0] x = 8'($urandom);
            bit ci = 1'($urandom), si = 1'($urandom);
            int lhs = x[0] + x[1] + x[2] + 2*(x[3] + x[4] + x[5]) + si + ci;
            din = x; carry_in = ci; share_in = si; #1;
            chk("R6", 32'(res[0] + 2*res[1] + 4*carry_out + 4*share_out), 32'(lhs));
        end
        idle(8'h00, 1'b0, 1'b0);

        // R4: extended mode keeps register 1 cleared even when loading ones
        wcfg(3'd4, 32'd1);
        step(1'b0, 3'd0, 32'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF);
        chk("R4", {28'd0, q}, 32'hD);

        // random scenario against the model
        for (int n = 0; n < 3000; n++) begin
            bit we = ($urandom % 8) == 0;
            bit [2:0] ad = 3'($urandom % 6);
            bit [31:0] wd = $urandom;
            step(we, ad, wd, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4) != 0, ($urandom % 16) == 0, ($urandom % 8) == 0,
                 4'($urandom));
        end

        // R13: asynchronous clear in mid-cycle
        step(1'b0, 3'd0, 32'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF);
        #0.5 rst_n = 1'b0; #0.5;
        chk("R13", {28'd0, q}, 32'd0);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(8'h3C, 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule